// File: doc/BRIEF.md
# I2C Bus Front-End Conditioner

This block conditions the raw clock and data lines of an I2C target before a protocol engine sees them. Each line is brought into the system clock domain through a two-stage synchroniser, then passed through a run-length deglitcher that ignores any level change that does not persist longer than the spike limit. From the cleaned lines it raises one-cycle START and STOP flags.

On the return path it gates the engine's SDA pull-down request. After every falling edge of the cleaned clock, the current drive level is frozen for a hold interval. This keeps the data output stable across the slow, ill-defined part of the clock fall. A watchdog times how long the cleaned clock stays low. When the limit is reached, it sends a one-cycle reset to the protocol engine so that a stuck bus cannot wedge the interface.

The spike limit, hold interval and timeout are given in nanoseconds or microseconds together with the system clock frequency. Each is converted to a cycle count, rounded up. The watchdog runs whenever its disable input is low, so a control register that resets to zero leaves it active after power-up. The block serves SCL rates from DC up to 400 kHz.

Top module: `i2c_bus_frontend`

## Requirements
- R1: While reset is asserted and on the first cycle after it, the outputs are idle: `scl_clean`=1, `sda_clean`=1, `start_det`=0, `stop_det`=0, `sda_pull`=0, `eng_rst`=0.
- R2: A pin level that differs from the cleaned level for FILT_CYC synchronised cycles or fewer has no effect on the cleaned line. A level held for FILT_CYC+1 cycles or more is adopted.
- R3: A lasting pin change appears on the cleaned line FILT_CYC+3 clock cycles after the pin changes. This covers two synchroniser stages and FILT_CYC+1 filter cycles.
- R4: Each duration is the product of its time parameter and CLK_HZ, rounded up to whole cycles. Examples: 18 ns at 250 MHz gives 5 cycles, 37 ns gives 10 cycles and 2 us gives 500 cycles.
- R5: `start_det` is a one-cycle pulse raised when cleaned SDA falls while cleaned SCL is high. SDA changes while SCL is low raise no pulse.
- R6: `stop_det` is a one-cycle pulse raised when cleaned SDA rises while cleaned SCL is high. It is never high in the same cycle as `start_det`.
- R7: After a falling edge of cleaned SCL, `sda_pull` keeps its value for at least HOLD_CYC cycles. It then takes the value of `eng_sda_oe` no later than HOLD_CYC+2 cycles after that edge.
- R8: Outside a hold interval, `sda_pull` follows `eng_sda_oe` with one cycle of latency.
- R9: With `tmo_off`=0, `eng_rst` pulses for one cycle exactly TMO_CYC cycles after cleaned SCL falls, if SCL is still low. A low period of TMO_CYC-1 cycles produces no pulse.
- R10: Only one `eng_rst` pulse is produced per low period of cleaned SCL. The watchdog is re-armed only once cleaned SCL has been high.
- R11: While `tmo_off`=1 the watchdog neither counts nor pulses. After `tmo_off` returns to 0 with SCL still low, the pulse comes TMO_CYC cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_pin | input | 1 | Raw SCL from the pad |
| sda_pin | input | 1 | Raw SDA from the pad |
| eng_sda_oe | input | 1 | Protocol engine's request to pull SDA low |
| tmo_off | input | 1 | 1 disables the SCL-low watchdog |
| scl_clean | output | 1 | Synchronised, deglitched SCL |
| sda_clean | output | 1 | Synchronised, deglitched SDA |
| start_det | output | 1 | One-cycle START flag |
| stop_det | output | 1 | One-cycle STOP flag |
| sda_pull | output | 1 | Hold-delayed SDA pull-down enable to the pad |
| eng_rst | output | 1 | One-cycle reset to the protocol engine on SCL-low timeout |

## Verification
The assertions cover several properties on every cycle. A cleaned line never changes sooner than FILT_CYC cycles after its previous change. START and STOP are never raised together and never last two cycles. `sda_pull` stays fixed during the hold window after each clock fall. `eng_rst` is one cycle wide, fires at most once per low period, and only while the watchdog is enabled. Other behaviour can only be shown by the bench scenarios. These include the exact filter acceptance threshold for both polarities, the end-to-end latency, and the timeout boundary at TMO_CYC-1 versus TMO_CYC. They also include the restart of the count after the watchdog is re-enabled, and the absence of flags when SDA changes inside a real byte transfer.

// File: rtl/i2c_fe_pkg.sv
package i2c_fe_pkg;

  localparam int LINE_SCL = 0;
  localparam int LINE_SDA = 1;
  localparam int N_LINES  = 2;

  // Convert a duration in nanoseconds to clock cycles, rounding up.
  function automatic int ns_to_cycles(input longint clk_hz, input longint dur_ns);
    longint prod;
    prod = clk_hz * dur_ns;
    return int'((prod + 64'd999_999_999) / 64'd1_000_000_000);
  endfunction

  // Convert a duration in microseconds to clock cycles, rounding up.
  function automatic int us_to_cycles(input longint clk_hz, input longint dur_us);
    longint prod;
    prod = clk_hz * dur_us;
    return int'((prod + 64'd999_999) / 64'd1_000_000);
  endfunction

endpackage

// File: rtl/i2c_fe_deglitch.sv
module i2c_fe_deglitch #(
  parameter int FILT_CYC = 25
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_raw,
  output logic line_clean
);
  localparam int CW = (FILT_CYC < 1) ? 1 : $clog2(FILT_CYC + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] run_cnt;
  logic          sync_lvl;

  assign sync_lvl = sync_q[1];

  // two-stage synchroniser, idle-high after reset
  always_ff @(posedge clk) begin
    if (rst) sync_q <= 2'b11;
    else     sync_q <= {sync_q[0], pin_raw};
  end

  // run-length filter: adopt a new level only after FILT_CYC+1 differing cycles
  always_ff @(posedge clk) begin
    if (rst) begin
      line_clean <= 1'b1;
      run_cnt    <= '0;
    end else if (sync_lvl != line_clean) begin
      if (run_cnt == CW'(FILT_CYC)) begin
        line_clean <= sync_lvl;
        run_cnt    <= '0;
      end else begin
        run_cnt <= run_cnt + CW'(1);
      end
    end else begin
      run_cnt <= '0;
    end
  end

  // checker state: cycles since the cleaned line last changed
  logic          chk_prev;
  logic [CW-1:0] chk_age;
  always_ff @(posedge clk) begin
    if (rst) begin
      chk_prev <= 1'b1;
      chk_age  <= '0;
    end else begin
      chk_prev <= line_clean;
      if (chk_prev != line_clean)          chk_age <= '0;
      else if (chk_age != CW'(FILT_CYC))   chk_age <= chk_age + CW'(1);
    end
  end

  // R2
  glitch_reject_chk: assert property (@(posedge clk) disable iff (rst)
    (chk_prev != line_clean) |-> (chk_age == CW'(FILT_CYC)));

endmodule

// File: rtl/i2c_fe_cond.sv
module i2c_fe_cond (
  input  logic clk,
  input  logic rst,
  input  logic scl_clean,
  input  logic sda_clean,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q     <= 1'b1;
      sda_q     <= 1'b1;
      start_det <= 1'b0;
      stop_det  <= 1'b0;
    end else begin
      scl_q     <= scl_clean;
      sda_q     <= sda_clean;
      start_det <= scl_q & scl_clean &  sda_q & ~sda_clean;
      stop_det  <= scl_q & scl_clean & ~sda_q &  sda_clean;
    end
  end

  // R6
  cond_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({start_det, stop_det}));

  // R5
  start_single_chk: assert property (@(posedge clk) disable iff (rst)
    start_det |=> !start_det);

  // R6
  stop_single_chk: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !stop_det);

endmodule

// File: rtl/i2c_fe_hold.sv
module i2c_fe_hold #(
  parameter int HOLD_CYC = 75
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_clean,
  input  logic eng_oe,
  output logic sda_pull
);
  localparam int HW = (HOLD_CYC < 1) ? 1 : $clog2(HOLD_CYC + 1);

  logic          scl_q;
  logic [HW-1:0] hold_cnt;
  logic          scl_fall;

  assign scl_fall = scl_q & ~scl_clean;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q    <= 1'b1;
      hold_cnt <= '0;
      sda_pull <= 1'b0;
    end else begin
      scl_q <= scl_clean;
      if (scl_fall)             hold_cnt <= HW'(HOLD_CYC);
      else if (hold_cnt != '0)  hold_cnt <= hold_cnt - HW'(1);
      if (!scl_fall && hold_cnt == '0) sda_pull <= eng_oe;
    end
  end

  // checker state: cycles elapsed since the last detected fall, saturating
  logic [HW-1:0] chk_age;
  always_ff @(posedge clk) begin
    if (rst)                              chk_age <= HW'(HOLD_CYC);
    else if (scl_fall)                    chk_age <= '0;
    else if (chk_age != HW'(HOLD_CYC))    chk_age <= chk_age + HW'(1);
  end

  // R7
  hold_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
    scl_fall |=> $stable(sda_pull));

  // R7
  hold_window_chk: assert property (@(posedge clk) disable iff (rst)
    (chk_age < HW'(HOLD_CYC)) |=> $stable(sda_pull));

endmodule

// File: rtl/i2c_fe_watchdog.sv
module i2c_fe_watchdog #(
  parameter int TMO_CYC = 8_750_000
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_clean,
  input  logic tmo_off,
  output logic eng_rst
);
  localparam int TW = $clog2(TMO_CYC + 1);

  logic [TW-1:0] low_cnt;
  logic          tripped;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_cnt <= '0;
      tripped <= 1'b0;
      eng_rst <= 1'b0;
    end else begin
      eng_rst <= 1'b0;
      if (scl_clean) begin
        low_cnt <= '0;
        tripped <= 1'b0;
      end else if (tmo_off) begin
        low_cnt <= '0;
      end else if (!tripped) begin
        if (low_cnt == TW'(TMO_CYC - 1)) begin
          eng_rst <= 1'b1;
          tripped <= 1'b1;
          low_cnt <= '0;
        end else begin
          low_cnt <= low_cnt + TW'(1);
        end
      end
    end
  end

  // checker state: pulses issued during the current low period
  logic [1:0] chk_pulses;
  logic       chk_off_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      chk_pulses <= '0;
      chk_off_q  <= 1'b0;
    end else begin
      chk_off_q <= tmo_off;
      if (scl_clean)                          chk_pulses <= '0;
      else if (eng_rst && chk_pulses != 2'd3) chk_pulses <= chk_pulses + 2'd1;
    end
  end

  // R9
  rst_single_chk: assert property (@(posedge clk) disable iff (rst)
    eng_rst |=> !eng_rst);

  // R10
  rst_once_per_low_chk: assert property (@(posedge clk) disable iff (rst)
    eng_rst |-> (chk_pulses == 2'd0));

  // R11
  rst_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
    eng_rst |-> !chk_off_q);

endmodule

// File: rtl/i2c_bus_frontend.sv
module i2c_bus_frontend
  import i2c_fe_pkg::*;
#(
  parameter longint CLK_HZ  = 250_000_000,
  parameter int     FILT_NS = 100,
  parameter int     HOLD_NS = 300,
  parameter int     TMO_US  = 35_000
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_pin,
  input  logic sda_pin,
  input  logic eng_sda_oe,
  input  logic tmo_off,
  output logic scl_clean,
  output logic sda_clean,
  output logic start_det,
  output logic stop_det,
  output logic sda_pull,
  output logic eng_rst
);
  localparam int FILT_CYC = ns_to_cycles(CLK_HZ, longint'(FILT_NS));
  localparam int HOLD_CYC = ns_to_cycles(CLK_HZ, longint'(HOLD_NS));
  localparam int TMO_CYC  = us_to_cycles(CLK_HZ, longint'(TMO_US));

  logic [N_LINES-1:0] raw_lines;
  logic [N_LINES-1:0] clean_lines;

  assign raw_lines[LINE_SCL] = scl_pin;
  assign raw_lines[LINE_SDA] = sda_pin;

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    i2c_fe_deglitch #(.FILT_CYC(FILT_CYC)) u_dg (
      .clk        (clk),
      .rst        (rst),
      .pin_raw    (raw_lines[g]),
      .line_clean (clean_lines[g])
    );
  end

  assign scl_clean = clean_lines[LINE_SCL];
  assign sda_clean = clean_lines[LINE_SDA];

  i2c_fe_cond u_cond (
    .clk       (clk),
    .rst       (rst),
    .scl_clean (scl_clean),
    .sda_clean (sda_clean),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c_fe_hold #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk       (clk),
    .rst       (rst),
    .scl_clean (scl_clean),
    .eng_oe    (eng_sda_oe),
    .sda_pull  (sda_pull)
  );

  i2c_fe_watchdog #(.TMO_CYC(TMO_CYC)) u_wd (
    .clk       (clk),
    .rst       (rst),
    .scl_clean (scl_clean),
    .tmo_off   (tmo_off),
    .eng_rst   (eng_rst)
  );

endmodule

// File: tb/tb_i2c_bus_frontend.sv
module tb_i2c_bus_frontend;

  // R4: 18 ns -> 5, 37 ns -> 10, 2 us -> 500 cycles at 250 MHz
  localparam int FILT = 5;
  localparam int HOLD = 10;
  localparam int TMO  = 500;
  localparam int HP   = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_pin = 1'b1, sda_pin = 1'b1, eng_sda_oe = 1'b0, tmo_off = 1'b0;
  logic scl_clean, sda_clean, start_det, stop_det, sda_pull, eng_rst;

  int errors = 0;
  int checks = 0;
  int n_start = 0, n_stop = 0, n_rst = 0;

  always #2 clk = ~clk;

  i2c_bus_frontend #(
    .CLK_HZ(250_000_000), .FILT_NS(18), .HOLD_NS(37), .TMO_US(2)
  ) dut (
    .clk(clk), .rst(rst), .scl_pin(scl_pin), .sda_pin(sda_pin),
    .eng_sda_oe(eng_sda_oe), .tmo_off(tmo_off),
    .scl_clean(scl_clean), .sda_clean(sda_clean),
    .start_det(start_det), .stop_det(stop_det),
    .sda_pull(sda_pull), .eng_rst(eng_rst)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (start_det) n_start++;
      if (stop_det)  n_stop++;
      if (eng_rst)   n_rst++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150_000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  task automatic bit_out(input logic b);
    scl_pin = 1'b0; step(HP);
    sda_pin = b;    step(HP);
    scl_pin = 1'b1; step(HP);
  endtask

  initial begin : main
    int k, s0, p0, r0;
    bit seen;

    // R1: reset state
    step(3);
    check(scl_clean && sda_clean && !start_det && !stop_det && !sda_pull && !eng_rst,
          "R1 reset idle", {scl_clean, sda_clean, start_det, stop_det, sda_pull, eng_rst}, 6'b110000);
    rst = 1'b0;
    step(1);
    check(scl_clean && sda_clean && !start_det && !stop_det && !sda_pull && !eng_rst,
          "R1 after reset", {scl_clean, sda_clean, start_det, stop_det, sda_pull, eng_rst}, 6'b110000);
    step(20);

    // R3: latency of a lasting change
    scl_pin = 1'b0; k = 0;
    while (scl_clean !== 1'b0 && k < 50) begin step(1); k++; end
    check(k == FILT + 3, "R3 fall latency", k, FILT + 3);
    step(20);
    scl_pin = 1'b1; k = 0;
    while (scl_clean !== 1'b1 && k < 50) begin step(1); k++; end
    check(k == FILT + 3, "R3 rise latency", k, FILT + 3);
    step(20);

    // R2: SCL low-going glitch sweep with line high
    tmo_off = 1'b1;
    for (int w = 1; w <= FILT + 3; w++) begin
      seen = 0;
      scl_pin = 1'b0; step(w); scl_pin = 1'b1;
      for (int j = 0; j < 2 * FILT + 8; j++) begin step(1); if (!scl_clean) seen = 1; end
      check(seen == (w > FILT), "R2 scl low glitch", seen, int'(w > FILT));
    end
    // R2: SCL high-going glitch sweep with line low
    scl_pin = 1'b0; step(FILT + 8);
    for (int w = 1; w <= FILT + 3; w++) begin
      seen = 0;
      scl_pin = 1'b1; step(w); scl_pin = 1'b0;
      for (int j = 0; j < 2 * FILT + 8; j++) begin step(1); if (scl_clean) seen = 1; end
      check(seen == (w > FILT), "R2 scl high glitch", seen, int'(w > FILT));
    end
    scl_pin = 1'b1; step(FILT + 8);
    tmo_off = 1'b0;

    // R2 R5 R6: SDA low glitches with SCL high -> START/STOP pair only when accepted
    for (int w = 1; w <= FILT + 3; w++) begin
      s0 = n_start; p0 = n_stop;
      sda_pin = 1'b0; step(w); sda_pin = 1'b1;
      step(2 * FILT + 8);
      check((n_start - s0) == int'(w > FILT), "R5 sda glitch start", n_start - s0, int'(w > FILT));
      check((n_stop - p0) == int'(w > FILT), "R6 sda glitch stop", n_stop - p0, int'(w > FILT));
    end

    // R5 R6: one transaction with a repeated START
    s0 = n_start; p0 = n_stop;
    sda_pin = 1'b0; step(HP);
    for (int b = 0; b < 8; b++) bit_out(logic'((8'hA5 >> (7 - b)) & 1));
    scl_pin = 1'b0; step(HP); sda_pin = 1'b1; step(HP);
    scl_pin = 1'b1; step(HP); sda_pin = 1'b0; step(HP);
    for (int b = 0; b < 4; b++) bit_out(logic'(b & 1));
    scl_pin = 1'b0; step(HP); sda_pin = 1'b0; step(HP);
    scl_pin = 1'b1; step(HP); sda_pin = 1'b1; step(HP);
    check((n_start - s0) == 2, "R5 starts in transfer", n_start - s0, 2);
    check((n_stop - p0) == 1, "R6 stops in transfer", n_stop - p0, 1);

    // R7: hold after clean SCL fall
    tmo_off = 1'b1;
    eng_sda_oe = 1'b0; step(4);
    scl_pin = 1'b0;
    while (scl_clean !== 1'b0) step(1);
    eng_sda_oe = 1'b1; k = 0;
    while (sda_pull !== 1'b1 && k < 100) begin step(1); k++; end
    check(k >= HOLD && k <= HOLD + 2, "R7 hold delay", k, HOLD + 2);

    // R8: outside the hold window the pull follows in one cycle
    step(5);
    eng_sda_oe = 1'b0; step(1);
    check(sda_pull == 1'b0, "R8 follow release", sda_pull, 0);
    eng_sda_oe = 1'b1; step(1);
    check(sda_pull == 1'b1, "R8 follow assert", sda_pull, 1);
    scl_pin = 1'b1; step(FILT + 8);
    eng_sda_oe = 1'b0; step(2);
    check(sda_pull == 1'b0, "R8 follow with scl high", sda_pull, 0);

    // R11: disabled watchdog stays silent, restarts on enable
    r0 = n_rst;
    scl_pin = 1'b0;
    while (scl_clean !== 1'b0) step(1);
    step(2 * TMO);
    check(n_rst == r0, "R11 disabled no pulse", n_rst - r0, 0);
    tmo_off = 1'b0; k = 0;
    while (eng_rst !== 1'b1 && k < 3 * TMO) begin step(1); k++; end
    check(k == TMO, "R11 restart count", k, TMO);
    step(1);
    check(eng_rst == 1'b0, "R9 pulse width", eng_rst, 0);

    // R10: no second pulse in the same low period
    r0 = n_rst;
    step(2 * TMO);
    check(n_rst == r0, "R10 single per low", n_rst - r0, 0);
    scl_pin = 1'b1; step(FILT + 8);

    // R9 R10: re-armed after high, timing from clean fall
    scl_pin = 1'b0;
    while (scl_clean !== 1'b0) step(1);
    k = 0;
    while (eng_rst !== 1'b1 && k < 3 * TMO) begin step(1); k++; end
    check(k == TMO, "R9 timeout cycles", k, TMO);
    scl_pin = 1'b1; step(FILT + 8);

    // R9: boundary TMO-1 low cycles gives nothing, TMO gives one pulse
    r0 = n_rst;
    scl_pin = 1'b0; step(TMO - 1); scl_pin = 1'b1; step(FILT + 8);
    check(n_rst == r0, "R9 just under timeout", n_rst - r0, 0);
    r0 = n_rst;
    scl_pin = 1'b0; step(TMO); scl_pin = 1'b1; step(FILT + 8);
    check(n_rst - r0 == 1, "R9 exactly timeout", n_rst - r0, 1);

    finish_run();
  end

endmodule